// File: doc/BRIEF.md
# Frame Timestamp and Word-Index Capture

This block sits beside a passive SPI listener and marks where each monitored frame begins, and optionally where it ends, in both time and data. A free-running 32-bit microsecond counter is built from the system clock through a prescaler. The word index counts the data words that the listener has written to its buffer. On each chip-select edge the block takes both values, joins them into one record and queues it, so that a logger can later cut the raw word stream into timed frames.

The word index wraps at the size of the data buffer. Both the half-way and the wrap points raise a one-cycle pulse, so the consumer of the ping-pong data buffer can drain one half while the other half fills.

Records leave the block over a valid/ready stream. `rec_valid` stays high, with `rec_data` unchanged, until a cycle in which `rec_ready` is also high, and that cycle pops the record. Back-pressure is absorbed by a 16-entry queue. A record that arrives while the queue is full is dropped and sets a sticky overflow flag.

Top module: `frame_mark_capture`

## Requirements
- R1: While reset is held and just after it is released, `rec_valid`, `rec_overflow`, `half_pulse` and `full_pulse` are all 0.
- R2: The timestamp starts at 0 on reset release and advances by one every CLK_DIV clock edges. A record whose chip-select change is driven after K active edges carries timestamp floor((K+2)/CLK_DIV).
- R3: A falling `cs_n` produces exactly one start record with type bit 0. It becomes visible on `rec_valid` three clock edges after the change is driven: two synchroniser stages plus the queue write.
- R4: A rising `cs_n` produces an end record with type bit 1 only when `end_rec_en` is 1. When `end_rec_en` is 0, no record is queued for that edge.
- R5: The word index counts clock edges at which `word_stb` is 1, modulo BUF_WORDS. A record carries the index value held just before the edge that writes it.
- R6: `half_pulse` is 1 for exactly the one cycle after the index has stepped to BUF_WORDS/2. `full_pulse` is 1 for exactly the one cycle after the index has wrapped to 0.
- R7: Records leave in arrival order. While `rec_valid` is 1 and `rec_ready` is 0, both `rec_valid` and `rec_data` hold. A record is removed only on an edge where both are 1.
- R8: A record that arrives while 16 records are queued is dropped, even if the same cycle pops one, and `rec_overflow` goes to 1. The queued records stay intact. The flag stays 1 until a cycle with `ovf_clear` high; a drop in that same cycle keeps it set.
- R9: The record layout is bit 48 = type (0 start, 1 end), bits 47:16 = timestamp, bits 15:0 = word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Monitored chip select, asynchronous, low during a frame |
| word_stb | input | 1 | One received word written to the data buffer this cycle |
| end_rec_en | input | 1 | Also queue a record on the rising chip-select edge |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| rec_valid | output | 1 | A record is available |
| rec_ready | input | 1 | The consumer takes the record this cycle |
| rec_data | output | 49 | Record: type, timestamp, word index |
| rec_overflow | output | 1 | Sticky: a record was dropped |
| half_pulse | output | 1 | Data buffer reached its half point |
| full_pulse | output | 1 | Data buffer wrapped |

## Verification
The assertions assume that every level of `cs_n` lasts longer than the synchroniser depth plus one cycle, so that no edge is merged or lost. They also assume that `word_stb` stands for at most one word per cycle. The stimulus holds every chip-select level for at least five cycles and drives strobes only between clock edges. It holds `rec_ready` low for long stretches, to exercise the hold rule and the overflow path.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam int STAMP_W = 32;
  localparam int IDX_W   = 16;

  typedef struct packed {
    logic               is_end;
    logic [STAMP_W-1:0] stamp;
    logic [IDX_W-1:0]   widx;
  } fmc_rec_t;

  localparam int REC_W = $bits(fmc_rec_t);
endpackage

// File: rtl/fmc_us_timer.sv
module fmc_us_timer #(
  parameter int CLK_DIV = 100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic [fmc_pkg::STAMP_W-1:0] stamp
);
  localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      stamp <= '0;
    end else if (pre == LAST) begin
      pre   <= '0;
      stamp <= stamp + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R2: the timestamp never jumps by more than one step
  assert_stamp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stamp == $past(stamp) || stamp == $past(stamp) + 32'd1));
endmodule

// File: rtl/fmc_cs_edge.sv
module fmc_cs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], cs_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
  assign rise = ~prev & chain[STAGES-1];

  // R3: every detected edge is a single-cycle pulse
  assert_fall_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
  assert_rise_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fmc_word_pos.sv
module fmc_word_pos #(
  parameter int BUF_WORDS = 1024
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      word_stb,
  output logic [fmc_pkg::IDX_W-1:0] widx,
  output logic                      half_pulse,
  output logic                      full_pulse
);
  localparam int IW = fmc_pkg::IDX_W;
  localparam logic [IW-1:0] TOP  = IW'(BUF_WORDS - 1);
  localparam logic [IW-1:0] MIDM = IW'(BUF_WORDS / 2 - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx       <= '0;
      half_pulse <= 1'b0;
      full_pulse <= 1'b0;
    end else begin
      half_pulse <= word_stb && (widx == MIDM);
      full_pulse <= word_stb && (widx == TOP);
      if (word_stb) widx <= (widx == TOP) ? '0 : widx + 1'b1;
    end
  end

  // R5: the index stays inside the buffer
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(widx) < BUF_WORDS);
  // R6: the pulses line up with the index they announce
  assert_full_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_pulse |-> widx == '0);
  assert_half_at_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    half_pulse |-> 32'(widx) == BUF_WORDS / 2);
endmodule

// File: rtl/fmc_rec_fifo.sv
module fmc_rec_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 49
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         ovf_clear,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic [AW:0]  count;
  logic         full, pop, take;

  assign count     = wr_ptr - rd_ptr;
  assign full      = (count == (AW+1)'(DEPTH));
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;
  assign take      = push && !full;
  assign out_data  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      if (take) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && full)   overflow <= 1'b1;
      else if (ovf_clear) overflow <= 1'b0;
    end
  end

  // R7: a stalled record holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  // R8: a dropped record raises the flag, and it stays until cleared
  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overflow);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clear) |=> overflow);
endmodule

// File: rtl/frame_mark_capture.sv
module frame_mark_capture #(
  parameter int CLK_DIV     = 100,
  parameter int BUF_WORDS   = 1024,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      word_stb,
  input  logic                      end_rec_en,
  input  logic                      ovf_clear,
  output logic                      rec_valid,
  input  logic                      rec_ready,
  output logic [fmc_pkg::REC_W-1:0] rec_data,
  output logic                      rec_overflow,
  output logic                      half_pulse,
  output logic                      full_pulse
);
  import fmc_pkg::*;

  logic [STAMP_W-1:0] stamp;
  logic [IDX_W-1:0]   widx;
  logic               fall, rise, push;
  fmc_rec_t           rec;

  fmc_us_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .stamp(stamp));

  fmc_cs_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall(fall), .rise(rise));

  fmc_word_pos #(.BUF_WORDS(BUF_WORDS)) u_pos (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .widx(widx),
    .half_pulse(half_pulse), .full_pulse(full_pulse));

  assign push       = fall || (rise && end_rec_en);
  assign rec.is_end = rise;
  assign rec.stamp  = stamp;
  assign rec.widx   = widx;

  fmc_rec_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(rec),
    .ovf_clear(ovf_clear), .out_valid(rec_valid), .out_ready(rec_ready),
    .out_data(rec_data), .overflow(rec_overflow));

  // R4: no end record is queued while end capture is off
  assert_no_end_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !end_rec_en && !rec_valid) |=> !rec_valid);
endmodule

// File: tb/frame_mark_capture_bench.sv
module frame_mark_capture_bench;
  localparam int DIV = 100;
  localparam int BUF = 1024;

  // Vector fields: {idle gap cycles, words in frame, end capture enabled}
  localparam logic [24:0] VEC [0:4] = '{
    {16'd150, 8'd2,  1'b1},
    {16'd37,  8'd48, 1'b1},
    {16'd420, 8'd1,  1'b0},
    {16'd5,   8'd40, 1'b1},
    {16'd260, 8'd3,  1'b1}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, word_stb = 0, end_rec_en = 0;
  logic ovf_clear = 0, rec_ready = 0;
  logic rec_valid, rec_overflow, half_pulse, full_pulse;
  logic [48:0] rec_data;

  int checks = 0, fails = 0, edges = 0, widx = 0, qn = 0;
  logic [48:0] expq [0:31];

  always #5 clk = ~clk;
  always @(posedge clk) if (!rst_n) edges <= 0; else edges <= edges + 1;

  frame_mark_capture u_frame_mark_capture (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .word_stb(word_stb),
    .end_rec_en(end_rec_en), .ovf_clear(ovf_clear), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_data(rec_data), .rec_overflow(rec_overflow),
    .half_pulse(half_pulse), .full_pulse(full_pulse));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_exp(input bit is_end);
    expq[qn] = {is_end, 32'((edges + 2) / DIV), 16'(widx)};
    qn = qn + 1;
  endtask

  task automatic frame(input int gap, input int nw, input bit en);
    end_rec_en = en;
    repeat (gap) @(negedge clk);
    cs_n = 0; add_exp(1'b0);
    repeat (3) @(negedge clk);
    if (nw > 0) begin
      word_stb = 1;
      for (int i = 0; i < nw; i++) begin
        @(negedge clk);
        widx = (widx + 1) % BUF;
      end
      word_stb = 0;
    end
    repeat (3) @(negedge clk);
    cs_n = 1;
    if (en) add_exp(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_check(input logic [48:0] exp, input string req);
    chk(rec_valid === 1'b1, req, 64'(rec_valid), 64'd1);
    chk(rec_data === exp, req, 64'(rec_data), 64'(exp));
    rec_ready = 1;
    @(negedge clk);
    rec_ready = 0;
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", edges);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [48:0] held;
    int hbad, fbad, hseen, fseen;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({rec_valid, rec_overflow, half_pulse, full_pulse} === 4'b0, "R1 in reset",
        64'({rec_valid, rec_overflow, half_pulse, full_pulse}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk({rec_valid, rec_overflow, half_pulse, full_pulse} === 4'b0, "R1 after release",
        64'({rec_valid, rec_overflow, half_pulse, full_pulse}), 64'd0);

    // Table walk: R2 R3 R4 R5 R9 with records stalled (ready low)
    foreach (VEC[v]) frame(int'(VEC[v][24:9]), int'(VEC[v][8:1]), VEC[v][0]);

    // R7: a stalled head holds its data
    held = rec_data;
    repeat (3) @(negedge clk);
    chk(rec_valid === 1'b1 && rec_data === held, "R7 hold under stall",
        64'(rec_data), 64'(held));

    // Drain in order: R2 R3 R4 R5 R7 R9
    for (int i = 0; i < qn; i++) pop_check(expq[i], "R3/R4/R9 table record");
    chk(rec_valid === 1'b0, "R4 no extra record", 64'(rec_valid), 64'd0);

    // R6 and R5 wrap: strobe BUF+3 words back to back
    hbad = 0; fbad = 0; hseen = 0; fseen = 0;
    word_stb = 1;
    for (int i = 0; i < BUF + 3; i++) begin
      @(negedge clk);
      widx = (widx + 1) % BUF;
      if (half_pulse !== (widx == BUF / 2)) hbad++;
      if (full_pulse !== (widx == 0)) fbad++;
      if (half_pulse === 1'b1) hseen++;
      if (full_pulse === 1'b1) fseen++;
    end
    word_stb = 0;
    chk(hbad == 0 && hseen == 1, "R6 half pulse", 64'(hseen), 64'd1);
    chk(fbad == 0 && fseen == 1, "R6 full pulse", 64'(fseen), 64'd1);
    qn = 0;
    frame(6, 2, 1'b1);
    pop_check(expq[0], "R5 wrapped index start");
    pop_check(expq[1], "R5 wrapped index end");

    // R8: seventeen records with the queue stalled
    qn = 0;
    for (int i = 0; i < 17; i++) frame(2, 1, 1'b0);
    chk(rec_overflow === 1'b1, "R8 overflow set", 64'(rec_overflow), 64'd1);
    for (int i = 0; i < 16; i++) pop_check(expq[i], "R8 kept records");
    chk(rec_valid === 1'b0, "R8 extra record dropped", 64'(rec_valid), 64'd0);
    chk(rec_overflow === 1'b1, "R8 flag sticky", 64'(rec_overflow), 64'd1);
    ovf_clear = 1;
    @(negedge clk);
    ovf_clear = 0;
    @(negedge clk);
    chk(rec_overflow === 1'b0, "R8 flag cleared", 64'(rec_overflow), 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule